// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of programmable debug triggers. For each access it decides whether any of them fires, and which one. An access carries a kind (instruction fetch, load or store), the current privilege level, an address and a data value. Each trigger first checks that it is enabled for that access kind and that privilege. It then takes either the address or the data as its operand, cut to the active word width. It compares the operand against its own compare register under one of six rules: exact equality, naturally aligned power-of-two region, unsigned at-or-above, unsigned strictly-below, or a masked compare of the low or the high half.

Triggers can be linked. A trigger with its link bit set only passes its result on to the next one. A group of linked triggers fires, at the index of its last member, only when every member matches. Among all firing triggers the lowest index wins. While the core is already halted in debug, nothing fires. The result is registered and appears one clock after a valid access. A write port loads one trigger's control word and compare value per cycle.

Top module: `dbg_trig_match`

## Requirements
- R1: After reset, `hit` and `hit_idx` are 0 and every control word is zero, so no trigger can fire until it is written.
- R2: A request with `in_debug` high gives `hit`=0 in the next cycle, whatever the trigger settings.
- R3: Access kind codes are 0 fetch, 1 load, 2 store and 3 none. A trigger takes part only if its control bit 5 (fetch), bit 6 (load) or bit 7 (store) matches the kind. Kind 3 enables no trigger.
- R4: Privilege codes are 0 user, 1 supervisor, 2 hypervisor and 3 machine. A trigger takes part only if its control bit 8, 9, 10 or 11 for that level is set.
- R5: Control bit 3 set selects `req_data` as the operand, and clear selects `req_addr`. Only the low XLEN bits of the operand are compared, so upper bits never affect the result.
- R6: Mode field (control bits 2:0) code 0 matches on operand == compare. Code 2 matches on operand >= compare, and code 3 on operand < compare, both unsigned.
- R7: Mode code 1 counts the run of ones at the bottom of the compare value (k), ignores the low k bits of both values and matches when the rest are equal. When k equals XLEN it always matches.
- R8: Mode code 4 takes the upper half of the compare value as a mask M, and matches when (operand & M) == (compare & M). Code 5 does the same with the operand shifted right by XLEN/2.
- R9: Mode codes 6 and 7 never match.
- R10: Control bit 4 links a trigger to the next one. A group is a run of linked triggers ended by an unlinked one. It fires, at the end index, only if every member passes. A group whose last trigger is linked never fires.
- R11: When several triggers fire, `hit_idx` gives the lowest firing index. `hit_idx` is always below NTRIG when `hit` is 1.
- R12: The result of a request with `req_valid` high appears on `hit`/`hit_idx` in the next cycle. A cycle without a valid request gives `hit`=0 and `hit_idx`=0 next.
- R13: A write with `cfg_we` high stores `cfg_ctl` and `cfg_cmp` into trigger `cfg_idx`. It affects requests from the following cycle on, not one presented in the same cycle. A write to an index of NTRIG or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Trigger index to write |
| cfg_ctl | input | 12 | Control word (mode, select, link, kind and privilege enables) |
| cfg_cmp | input | XLEN | Compare value |
| req_valid | input | 1 | Access request present |
| req_op | input | 2 | Access kind |
| req_priv | input | 2 | Current privilege level |
| req_addr | input | AW | Access address |
| req_data | input | AW | Access data |
| in_debug | input | 1 | Core already halted in debug; blocks every match |
| hit | output | 1 | A trigger fired on the previous request |
| hit_idx | output | IW | Index of the firing trigger, 0 when no hit |

## Verification
The hardest case to reach is a partly failing link group. It needs every trigger's link bit and match outcome to be set up at once, and then a single access whose result depends on the order in which the groups are scanned. The bench sweeps all sixteen link patterns against all sixteen match patterns. Each trigger gets an equality compare value that either equals the probe address or misses it by a trigger-specific offset, so any mix of passing and failing members occurs within one access. Compare modes are swept with operands made to fall just on, just above, just below and one bit away from the compare value. The upper address bits are filled with noise at the same time.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  typedef enum logic [2:0] {
    CMP_EQ   = 3'd0,
    CMP_POW2 = 3'd1,
    CMP_GE   = 3'd2,
    CMP_LT   = 3'd3,
    CMP_MLO  = 3'd4,
    CMP_MHI  = 3'd5
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  // bit 11 .. bit 0
  typedef struct packed {
    logic       en_m;
    logic       en_h;
    logic       en_s;
    logic       en_u;
    logic       en_store;
    logic       en_load;
    logic       en_fetch;
    logic       link;
    logic       use_data;
    logic [2:0] mode;
  } trig_ctl_t;

  localparam int CTL_W = $bits(trig_ctl_t);

endpackage

// File: rtl/dtm_cfg_bank.sv
module dtm_cfg_bank
  import dtm_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 32,
  parameter int IW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IW-1:0]               idx,
  input  trig_ctl_t                   ctl_in,
  input  logic [XLEN-1:0]             cmp_in,
  output trig_ctl_t [NTRIG-1:0]       ctl_q,
  output logic [NTRIG-1:0][XLEN-1:0]  cmp_q
);

  logic idx_in_range;
  assign idx_in_range = (idx < IW'(NTRIG));

  for (genvar g = 0; g < NTRIG; g++) begin : g_slot
    logic sel_slot;
    assign sel_slot = we && (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[g] <= '0;
        cmp_q[g] <= '0;
      end else if (sel_slot) begin
        ctl_q[g] <= ctl_in;
        cmp_q[g] <= cmp_in;
      end
    end
  end

  // R13: a write aimed past the last trigger leaves the bank untouched
  assert_oob_write_ignored_R13: assert property (
    @(posedge clk) disable iff (!rst_n)
    (we && !idx_in_range) |=> ($stable(ctl_q) && $stable(cmp_q)));

endmodule

// File: rtl/dtm_lane.sv
module dtm_lane
  import dtm_pkg::*;
#(
  parameter int AW   = 64,
  parameter int XLEN = 32
) (
  input  trig_ctl_t       ctl,
  input  logic [XLEN-1:0] cmp,
  input  logic [1:0]      acc,
  input  logic [1:0]      priv,
  input  logic [AW-1:0]   addr,
  input  logic [AW-1:0]   data,
  output logic            kind_ok,
  output logic            priv_ok,
  output logic            val_hit,
  output logic            lane_match
);

  localparam int HALF = XLEN / 2;

  function automatic int unsigned trail_ones(input logic [XLEN-1:0] v);
    int unsigned n = 0;
    logic run = 1'b1;
    for (int b = 0; b < XLEN; b++) begin
      run = run & v[b];
      if (run) n++;
    end
    return n;
  endfunction

  function automatic logic pow2_hit(input logic [XLEN-1:0] v, input logic [XLEN-1:0] c);
    logic [XLEN-1:0] keep;
    keep = {XLEN{1'b1}} << trail_ones(c);
    return (v & keep) == (c & keep);
  endfunction

  function automatic logic half_mask_hit(input logic [XLEN-1:0] v, input logic [XLEN-1:0] c,
                                         input logic use_high);
    logic [XLEN-1:0] msk;
    logic [XLEN-1:0] src;
    msk = c >> HALF;
    src = use_high ? (v >> HALF) : v;
    return (src & msk) == (c & msk);
  endfunction

  logic [XLEN-1:0] operand;
  assign operand = ctl.use_data ? data[XLEN-1:0] : addr[XLEN-1:0];

  if (AW > XLEN) begin : g_trunc
    logic unused_hi;
    assign unused_hi = ^{addr[AW-1:XLEN], data[AW-1:XLEN]};
  end

  always_comb begin
    case (acc_kind_e'(acc))
      ACC_FETCH: kind_ok = ctl.en_fetch;
      ACC_LOAD:  kind_ok = ctl.en_load;
      ACC_STORE: kind_ok = ctl.en_store;
      default:   kind_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (priv)
      2'd0:    priv_ok = ctl.en_u;
      2'd1:    priv_ok = ctl.en_s;
      2'd2:    priv_ok = ctl.en_h;
      default: priv_ok = ctl.en_m;
    endcase
  end

  always_comb begin
    case (cmp_mode_e'(ctl.mode))
      CMP_EQ:   val_hit = (operand == cmp);
      CMP_POW2: val_hit = pow2_hit(operand, cmp);
      CMP_GE:   val_hit = (operand >= cmp);
      CMP_LT:   val_hit = (operand <  cmp);
      CMP_MLO:  val_hit = half_mask_hit(operand, cmp, 1'b0);
      CMP_MHI:  val_hit = half_mask_hit(operand, cmp, 1'b1);
      default:  val_hit = 1'b0;
    endcase
  end

  assign lane_match = kind_ok && priv_ok && val_hit;

endmodule

// File: rtl/dtm_pick.sv
module dtm_pick #(
  parameter int NTRIG = 4,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] match,
  input  logic [NTRIG-1:0] link,
  input  logic             in_debug,
  output logic [NTRIG-1:0] grant,
  output logic             fire_any,
  output logic [IW-1:0]    fire_idx
);

  logic [NTRIG-1:0] fire;

  // group_ok carries "every earlier member of this group matched"
  always_comb begin
    logic group_ok;
    group_ok = 1'b1;
    fire     = '0;
    for (int i = 0; i < NTRIG; i++) begin
      fire[i]  = group_ok && match[i] && !link[i];
      group_ok = link[i] ? (group_ok && match[i]) : 1'b1;
    end
  end

  assign grant = fire & (~fire + NTRIG'(1));

  always_comb begin
    fire_idx = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (grant[i]) fire_idx = fire_idx | IW'(i);
    end
  end

  assign fire_any = (|fire) && !in_debug;

  // R11: at most one trigger is granted
  assert_grant_onehot_R11: assert property (
    @(posedge clk) disable iff (!rst_n) $onehot0(grant));

  for (genvar g = 0; g < NTRIG; g++) begin : g_chk
    // R10: only a matching, unlinked trigger can be the reported one
    assert_grant_at_group_end_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      grant[g] |-> (match[g] && !link[g]));
  end

endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
  import dtm_pkg::*;
#(
  parameter  int NTRIG = 4,
  parameter  int XLEN  = 32,
  parameter  int AW    = 64,
  localparam int IW    = $clog2(NTRIG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [11:0]      cfg_ctl,
  input  logic [XLEN-1:0]  cfg_cmp,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [1:0]       req_priv,
  input  logic [AW-1:0]    req_addr,
  input  logic [AW-1:0]    req_data,
  input  logic             in_debug,
  output logic             hit,
  output logic [IW-1:0]    hit_idx
);

  trig_ctl_t [NTRIG-1:0]       ctl_q;
  logic [NTRIG-1:0][XLEN-1:0]  cmp_q;
  logic [NTRIG-1:0]            kind_ok;
  logic [NTRIG-1:0]            priv_ok;
  logic [NTRIG-1:0]            val_hit;
  logic [NTRIG-1:0]            lane_match;
  logic [NTRIG-1:0]            link_v;
  logic [NTRIG-1:0]            grant;
  logic                        fire_any;
  logic [IW-1:0]               fire_idx;

  dtm_cfg_bank #(.NTRIG(NTRIG), .XLEN(XLEN), .IW(IW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .ctl_in (trig_ctl_t'(cfg_ctl)),
    .cmp_in (cfg_cmp),
    .ctl_q  (ctl_q),
    .cmp_q  (cmp_q)
  );

  for (genvar g = 0; g < NTRIG; g++) begin : g_lane
    dtm_lane #(.AW(AW), .XLEN(XLEN)) u_lane (
      .ctl        (ctl_q[g]),
      .cmp        (cmp_q[g]),
      .acc        (req_op),
      .priv       (req_priv),
      .addr       (req_addr),
      .data       (req_data),
      .kind_ok    (kind_ok[g]),
      .priv_ok    (priv_ok[g]),
      .val_hit    (val_hit[g]),
      .lane_match (lane_match[g])
    );
    assign link_v[g] = ctl_q[g].link;
  end

  dtm_pick #(.NTRIG(NTRIG), .IW(IW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (lane_match),
    .link     (link_v),
    .in_debug (in_debug),
    .grant    (grant),
    .fire_any (fire_any),
    .fire_idx (fire_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end else if (req_valid && fire_any) begin
      hit     <= 1'b1;
      hit_idx <= fire_idx;
    end else begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end
  end

  // R2: halted-in-debug requests never produce a hit
  assert_debug_blocks_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && in_debug) |=> !hit);

  // R12: an idle cycle leaves a cleared result behind it
  assert_idle_clears_R12: assert property (
    @(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!hit && hit_idx == '0));

  // R11: a reported index always names an existing trigger
  assert_idx_in_range_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    hit |-> (hit_idx < IW'(NTRIG)));

endmodule

// File: tb/dbg_trig_match_tb.sv
`timescale 1ns/1ps
module dbg_trig_match_tb;

  localparam int NT = 4;
  localparam int XL = 32;
  localparam int AWD = 64;
  localparam int IWD = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [IWD-1:0]  cfg_idx = '0;
  logic [11:0]     cfg_ctl = '0;
  logic [XL-1:0]   cfg_cmp = '0;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = '0;
  logic [1:0]      req_priv = '0;
  logic [AWD-1:0]  req_addr = '0;
  logic [AWD-1:0]  req_data = '0;
  logic            in_debug = 1'b0;
  logic            hit;
  logic [IWD-1:0]  hit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1bad_5eed;

  logic [11:0] sh_ctl [NT];
  logic [31:0] sh_cmp [NT];

  dbg_trig_match #(.NTRIG(NT), .XLEN(XL), .AW(AWD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ctl(cfg_ctl), .cfg_cmp(cfg_cmp), .req_valid(req_valid),
    .req_op(req_op), .req_priv(req_priv), .req_addr(req_addr),
    .req_data(req_data), .in_debug(in_debug), .hit(hit), .hit_idx(hit_idx)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // reference compare, written from the mode descriptions
  function automatic bit ref_cmp(input int mode, input logic [31:0] c, input logic [31:0] v);
    int k;
    logic [31:0] m;
    case (mode)
      0: return v == c;
      1: begin
        k = 0;
        while (k < 32 && c[k]) k++;
        if (k == 32) return 1'b1;
        return (v >> k) == (c >> k);
      end
      2: return v >= c;
      3: return v < c;
      4: begin m = {16'h0, c[31:16]}; return (v & m) == (c & m); end
      5: begin m = {16'h0, c[31:16]}; return ({16'h0, v[31:16]} & m) == (c & m); end
      default: return 1'b0;
    endcase
  endfunction

  // reference scan: walk upward, skip the rest of a group after a failure
  function automatic int ref_pick(input bit v, input logic [1:0] op, input logic [1:0] pr,
                                  input logic [63:0] a, input logic [63:0] d, input bit dbg);
    bit skipping = 1'b0;
    if (!v || dbg) return -1;
    for (int i = 0; i < NT; i++) begin
      logic [11:0] c = sh_ctl[i];
      bit en, ok;
      logic [31:0] operand;
      if (skipping) begin
        if (!c[4]) skipping = 1'b0;
        continue;
      end
      en = (op != 2'd3) && c[5 + op] && c[8 + pr];
      operand = c[3] ? d[31:0] : a[31:0];
      ok = en && ref_cmp(int'(c[2:0]), sh_cmp[i], operand);
      if (!ok) begin
        if (c[4]) skipping = 1'b1;
        continue;
      end
      if (!c[4]) return i;
    end
    return -1;
  endfunction

  task automatic check_out(input string tag, input int exp);
    bit eh = (exp >= 0);
    int ei = (exp >= 0) ? exp : 0;
    checks++;
    if (hit !== eh || int'(hit_idx) != ei) begin
      errors++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, hit, hit_idx, eh, ei);
    end
  endtask

  task automatic wr(input int idx, input logic [11:0] ctl, input logic [31:0] cmp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IWD'(idx); cfg_ctl = ctl; cfg_cmp = cmp;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NT) begin sh_ctl[idx] = ctl; sh_cmp[idx] = cmp; end
  endtask

  task automatic req(input string tag, input bit v, input logic [1:0] op, input logic [1:0] pr,
                     input logic [63:0] a, input logic [63:0] d, input bit dbg);
    int exp = ref_pick(v, op, pr, a, d, dbg);
    @(negedge clk);
    req_valid = v; req_op = op; req_priv = pr; req_addr = a; req_data = d; in_debug = dbg;
    @(negedge clk);
    req_valid = 1'b0; in_debug = 1'b0;
    check_out(tag, exp);
  endtask

  task automatic clear_all();
    for (int i = 0; i < NT; i++) wr(i, 12'h000, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: hit=%0b idx=%0d expected run to finish", hit, hit_idx);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) begin sh_ctl[i] = '0; sh_cmp[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, then a request against the all-disabled bank
    check_out("R1 reset", -1);
    req("R1 nothing enabled", 1'b1, 2'd0, 2'd3, 64'h0, 64'h0, 1'b0);

    // R3 R4: every kind/privilege enable against every kind/privilege
    for (int en = 0; en < 128; en++) begin
      wr(0, {en[6:0], 5'b00000}, 32'h0000_1234);
      for (int op = 0; op < 4; op++)
        for (int pr = 0; pr < 4; pr++)
          req("R3 R4 filter", 1'b1, op[1:0], pr[1:0], 64'h0000_1234, 64'h0, 1'b0);
    end

    // R6 R7 R8 R9 R5: compare modes with near-boundary operands and noisy upper bits
    for (int mode = 0; mode < 8; mode++) begin
      for (int n = 0; n < 168; n++) begin
        logic [31:0] c, v, r1, r2;
        logic [63:0] lowk;
        int k;
        r1 = rnd(); r2 = rnd();
        c = r1;
        case (n % 8)
          0: v = c;
          1: v = c + 1;
          2: v = c - 1;
          3: v = c ^ (32'h1 << (n % 32));
          4: v = r2;
          5, 6: begin
            k = n % 33;
            lowk = (64'd1 << k) - 64'd1;
            c = r1 << k | lowk[31:0];
            if (k == 32) c = 32'hffff_ffff;
            v = (n % 8 == 5) ? ((c & ~lowk[31:0]) | (r2 & lowk[31:0]))
                             : ((k < 32) ? (c ^ (32'h1 << k)) : r2);
          end
          default: v = {c[15:0], r2[15:0]};
        endcase
        wr(0, {7'b1000001, 2'b00, mode[2:0]}, c);
        req("R6 R7 R8 R9 modes", 1'b1, 2'd0, 2'd3, {rnd(), v}, {rnd(), rnd()}, 1'b0);
      end
    end

    // R5: operand select between address and data
    for (int n = 0; n < 24; n++) begin
      logic [31:0] c = rnd();
      bit use_d = n[0];
      wr(0, {7'b1111111, 1'b0, use_d, 3'd0}, c);
      req("R5 select", 1'b1, 2'd1, 2'd0, {rnd(), c}, {rnd(), c ^ 32'h10}, 1'b0);
      req("R5 select", 1'b1, 2'd2, 2'd1, {rnd(), c ^ 32'h4}, {rnd(), c}, 1'b0);
    end

    // R10 R11: every link pattern against every pass/fail pattern
    for (int lp = 0; lp < 16; lp++) begin
      for (int mp = 0; mp < 16; mp++) begin
        for (int i = 0; i < NT; i++)
          wr(i, {7'b1111111, lp[i], 1'b0, 3'd0}, mp[i] ? 32'h00C0_FFEE : 32'h00C0_FFEE + i + 1);
        req("R10 R11 link", 1'b1, 2'd0, 2'd2, 64'h00C0_FFEE, 64'h0, 1'b0);
      end
    end

    // R2: debug halt suppresses an otherwise firing trigger
    clear_all();
    wr(2, {7'b1111111, 5'b00000}, 32'h55);
    req("R2 debug", 1'b1, 2'd0, 2'd3, 64'h55, 64'h0, 1'b1);
    req("R2 control", 1'b1, 2'd0, 2'd3, 64'h55, 64'h0, 1'b0);

    // R12: no valid request means no hit
    req("R12 idle", 1'b0, 2'd0, 2'd3, 64'h55, 64'h0, 1'b0);

    // R13: write aimed past the bank changes nothing
    for (int i = NT; i < 8; i++) begin
      wr(i, {7'b1111111, 5'b00000}, 32'h77);
      req("R13 oob write", 1'b1, 2'd0, 2'd3, 64'h77, 64'h0, 1'b0);
    end

    // R13: a write in the same cycle as a request is seen only afterwards
    begin
      int exp;
      @(negedge clk);
      exp = ref_pick(1'b1, 2'd0, 2'd3, 64'h99, 64'h0, 1'b0);
      cfg_we = 1'b1; cfg_idx = 3'd0; cfg_ctl = {7'b1111111, 5'b00000}; cfg_cmp = 32'h99;
      req_valid = 1'b1; req_op = 2'd0; req_priv = 2'd3; req_addr = 64'h99; req_data = 64'h0;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check_out("R13 same-cycle write", exp);
      sh_ctl[0] = {7'b1111111, 5'b00000}; sh_cmp[0] = 32'h99;
      req("R13 after write", 1'b1, 2'd0, 2'd3, 64'h99, 64'h0, 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule